// File: doc/BRIEF.md
# Involutional Diffusion and Key-Mixing Layer

This block is the linear half of a round for a 64-bit block cipher. It takes the cipher state and a 64-bit round key. It moves the state bits through a fixed wire permutation, then splits the state into sixteen 4-bit nibbles. Each nibble passes through a small binary-matrix mixing box, and the round key is folded in at that point. The bits of each nibble are then crossed over, and the whole word goes through the same 64-bit permutation a second time.

With the key held at zero, the layer undoes itself. The same hardware therefore serves both directions of the cipher, and the caller does not have to invert anything. Both crossing tables are compile-time parameters. At elaboration, each table is checked to be a true permutation that is also its own inverse.

A parameter selects one of two timing variants. In the first, the result is a pure combinational path. In the second, a single output register loads whenever the input strobe is high, and a valid flag follows the strobe one cycle later.

Top module: `diff_key_layer`

## Requirements
- R1: For nibble input bits x3..x0 (bit 0 least significant), the mixing box gives out3 = x0^x1^x2, out2 = x0^x1^x3, out1 = x0^x2^x3 and out0 = x1^x2^x3. This is multiplication over GF(2) by the 4x4 matrix with ones everywhere except on its diagonal.
- R2: Round-key bit i is XORed onto mixing-box output bit i, before the nibble crossing and the final 64-bit crossing. With both tables set to identity and the state at zero, the result equals the key.
- R3: The order of the steps is fixed: 64-bit crossing, mixing with the key XOR, nibble crossing, then the 64-bit crossing again. A permutation table maps output bit i to input bit TABLE[i].
- R4: With a zero key, applying the layer twice returns the original state.
- R5: The layer is linear. The result for (state, key) equals the result for (state, 0) XOR the result for (0, key).
- R6: With PIPE=1, the result register loads the layer output on every clock edge where inValid is high and holds its value otherwise. outValid equals inValid delayed by one cycle.
- R7: While rstN is low, outValid and result are zero.
- R8: With PIPE=0, result is the combinational layer output and outValid equals inValid in the same cycle.
- R9: Each table must be a permutation that is its own inverse, and elaboration checks this. In the default 64-bit table, output bit 8r+c takes input bit 8c+r (an 8x8 transpose). In the default nibble table, output bit j takes input bit j^1.
- R10: With a zero key, a state containing exactly one set bit gives a result with exactly three set bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input strobe; loads the output register when PIPE=1 |
| stateIn | input | 64 | Cipher state entering the layer |
| roundKey | input | 64 | Round key mixed in at the diffusion step |
| outValid | output | 1 | Result qualifier |
| result | output | 64 | Layer output |

## Verification
The bench builds two instances. The first is registered (PIPE=1) and keeps the default transpose and pair-swap tables. A cycle-by-cycle model tracks it, and this instance exercises involution, linearity, hold behaviour and single-bit weight. The second is combinational (PIPE=0) with identity tables. With the crossings removed, each mixing equation and each key-bit position shows up directly at the output, and the same-cycle valid path can be checked.

// File: rtl/diff_layer_pkg.sv
`timescale 1ns/1ps
package diffLayerPkg;
  localparam int NIB_W       = 4;
  localparam int DEF_SIDE    = 8;
  localparam int DEF_STATE_W = DEF_SIDE * DEF_SIDE;
  localparam int DEF_NIBBLES = DEF_STATE_W / NIB_W;
  localparam int DEF_IDX_W   = $clog2(DEF_STATE_W);

  // control-to-datapath strobes
  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

  // 8x8 transpose: output bit 8r+c takes input bit 8c+r
  function automatic logic [DEF_STATE_W*DEF_IDX_W-1:0] defaultWirePerm();
    logic [DEF_STATE_W*DEF_IDX_W-1:0] t;
    t = '0;
    for (int i = 0; i < DEF_STATE_W; i++)
      t[i*DEF_IDX_W +: DEF_IDX_W] = DEF_IDX_W'((i % DEF_SIDE) * DEF_SIDE + i / DEF_SIDE);
    return t;
  endfunction

  // pair swap inside a nibble: entries {1,0,3,2}
  localparam logic [7:0] DEF_NIB_PERM = 8'hB1;
endpackage

// File: rtl/wire_perm.sv
`timescale 1ns/1ps
module wirePerm #(
  parameter int W = 4,
  parameter int IDX_W = 2,
  parameter logic [W*IDX_W-1:0] TABLE = 8'hE4
) (
  input  logic [W-1:0] permIn,
  output logic [W-1:0] permOut
);
  function automatic bit tableOk();
    for (int i = 0; i < W; i++) begin
      int idx;
      idx = int'(TABLE[i*IDX_W +: IDX_W]);
      if (idx >= W) return 1'b0;
      if (int'(TABLE[idx*IDX_W +: IDX_W]) != i) return 1'b0;
    end
    return 1'b1;
  endfunction

  initial begin
    p_table_involution_r9: assert (tableOk())
      else $error("permutation table is not a self-inverse permutation");
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign permOut[i] = permIn[TABLE[i*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/nibble_mix.sv
`timescale 1ns/1ps
module nibbleMix
  import diffLayerPkg::*;
#(
  parameter logic [7:0] NIB_PERM = DEF_NIB_PERM
) (
  input  logic [NIB_W-1:0] mixIn,
  input  logic [NIB_W-1:0] keyIn,
  output logic [NIB_W-1:0] mixOut
);
  logic [NIB_W-1:0] diffOut;
  logic [NIB_W-1:0] keyed;

  // each bit is the parity of the other three bits
  always_comb begin
    for (int r = 0; r < NIB_W; r++)
      diffOut[r] = ^(mixIn & ~(NIB_W'(1) << r));
  end

  assign keyed = diffOut ^ keyIn;

  wirePerm #(.W(NIB_W), .IDX_W(2), .TABLE(NIB_PERM)) u_nibPerm (
    .permIn (keyed),
    .permOut(mixOut)
  );
endmodule

// File: rtl/layer_datapath.sv
`timescale 1ns/1ps
module layerDatapath
  import diffLayerPkg::*;
#(
  parameter int NIBBLES = DEF_NIBBLES,
  parameter int PIPE = 1,
  parameter logic [NIBBLES*NIB_W*$clog2(NIBBLES*NIB_W)-1:0] WIRE_PERM = defaultWirePerm(),
  parameter logic [7:0] NIB_PERM = DEF_NIB_PERM
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobe_t                strobe,
  input  logic [NIBBLES*NIB_W-1:0]   stateIn,
  input  logic [NIBBLES*NIB_W-1:0]   keyIn,
  output logic [NIBBLES*NIB_W-1:0]   result
);
  localparam int STATE_W = NIBBLES * NIB_W;
  localparam int IDX_W = $clog2(STATE_W);

  logic [STATE_W-1:0] frontOut;
  logic [STATE_W-1:0] midOut;
  logic [STATE_W-1:0] layerOut;

  wirePerm #(.W(STATE_W), .IDX_W(IDX_W), .TABLE(WIRE_PERM)) u_front (
    .permIn (stateIn),
    .permOut(frontOut)
  );

  for (genvar n = 0; n < NIBBLES; n++) begin : g_nib
    nibbleMix #(.NIB_PERM(NIB_PERM)) u_mix (
      .mixIn (frontOut[n*NIB_W +: NIB_W]),
      .keyIn (keyIn[n*NIB_W +: NIB_W]),
      .mixOut(midOut[n*NIB_W +: NIB_W])
    );
  end

  wirePerm #(.W(STATE_W), .IDX_W(IDX_W), .TABLE(WIRE_PERM)) u_back (
    .permIn (midOut),
    .permOut(layerOut)
  );

  // zero in, zero out: linearity of the whole path
  p_zero_map_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateIn == '0 && keyIn == '0) |-> layerOut == '0);

  // a single state bit spreads to exactly three output bits
  p_single_bit_weight_r10: assert property (@(posedge clk) disable iff (!rstN)
    (keyIn == '0 && $countones(stateIn) == 1) |-> $countones(layerOut) == 3);

  if (PIPE != 0) begin : g_reg
    logic [STATE_W-1:0] resultQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resultQ <= '0;
      else if (strobe.load) resultQ <= layerOut;
    end
    assign result = resultQ;

    p_capture_r6: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(strobe.load)) |-> result == $past(layerOut));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(strobe.load)) |-> $stable(result));
  end else begin : g_comb
    assign result = layerOut;
  end
endmodule

// File: rtl/layer_control.sv
`timescale 1ns/1ps
module layerControl
  import diffLayerPkg::*;
#(
  parameter int PIPE = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  assign strobe.load = inValid;

  if (PIPE != 0) begin : g_reg
    logic validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) validQ <= 1'b0;
      else validQ <= inValid;
    end
    assign outValid = validQ;

    p_valid_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
      $past(rstN) |-> outValid == $past(inValid));
    p_reset_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
      !$past(rstN) |-> !outValid);
  end else begin : g_comb
    assign outValid = inValid;
  end
endmodule

// File: rtl/diff_key_layer.sv
`timescale 1ns/1ps
module diff_key_layer
  import diffLayerPkg::*;
#(
  parameter int NIBBLES = DEF_NIBBLES,
  parameter int PIPE = 1,
  parameter logic [NIBBLES*NIB_W*$clog2(NIBBLES*NIB_W)-1:0] WIRE_PERM = defaultWirePerm(),
  parameter logic [7:0] NIB_PERM = DEF_NIB_PERM
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [NIBBLES*NIB_W-1:0] stateIn,
  input  logic [NIBBLES*NIB_W-1:0] roundKey,
  output logic                     outValid,
  output logic [NIBBLES*NIB_W-1:0] result
);
  ctrlStrobe_t strobe;

  layerControl #(.PIPE(PIPE)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  layerDatapath #(
    .NIBBLES  (NIBBLES),
    .PIPE     (PIPE),
    .WIRE_PERM(WIRE_PERM),
    .NIB_PERM (NIB_PERM)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .stateIn(stateIn),
    .keyIn  (roundKey),
    .result (result)
  );
endmodule

// File: tb/sim_diff_key_layer.sv
`timescale 1ns/1ps
module sim_diff_key_layer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [63:0] stateIn = '0;
  logic [63:0] keyIn = '0;
  logic outValid0, outValid1;
  logic [63:0] result0, result1;
  int checks = 0;
  int errors = 0;
  logic expV = 1'b0;
  logic [63:0] expR = '0;

  always #10 clk = ~clk;

  function automatic logic [383:0] identWire();
    logic [383:0] t;
    for (int i = 0; i < 64; i++) t[i*6 +: 6] = 6'(i);
    return t;
  endfunction

  diff_key_layer u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stateIn(stateIn),
    .roundKey(keyIn), .outValid(outValid0), .result(result0));

  diff_key_layer #(.PIPE(0), .WIRE_PERM(identWire()), .NIB_PERM(8'hE4)) u1 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stateIn(stateIn),
    .roundKey(keyIn), .outValid(outValid1), .result(result1));

  // behavioural reference: index arithmetic and a GF(2) matrix product
  function automatic int tr(int i);
    return (i % 8) * 8 + i / 8;
  endfunction

  function automatic logic [63:0] refLayer(logic [63:0] x, logic [63:0] k, bit ident);
    logic [63:0] a, c, o;
    for (int i = 0; i < 64; i++) a[i] = ident ? x[i] : x[tr(i)];
    for (int n = 0; n < 16; n++) begin
      logic [3:0] y;
      for (int r = 0; r < 4; r++) begin
        y[r] = 1'b0;
        for (int col = 0; col < 4; col++)
          if (r != col) y[r] = y[r] ^ a[4*n + col];
      end
      y = y ^ k[4*n +: 4];
      for (int j = 0; j < 4; j++) c[4*n + j] = ident ? y[j] : y[j ^ 1];
    end
    for (int i = 0; i < 64; i++) o[i] = ident ? c[i] : c[tr(i)];
    return o;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cycle model of the registered instance (R6, R7)
  always @(posedge clk) begin
    if (!rstN) begin
      expV <= 1'b0;
      expR <= '0;
    end else begin
      expV <= inValid;
      if (inValid) expR <= refLayer(stateIn, keyIn, 1'b0);
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R6 outValid model", {63'b0, outValid0}, {63'b0, expV});
      chk("R6 result model", result0, expR);
    end
  end

  task automatic run0(logic [63:0] x, logic [63:0] k, output logic [63:0] y);
    @(negedge clk);
    stateIn = x; keyIn = k; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    y = result0;
  endtask

  task automatic set1(logic [63:0] x, logic [63:0] k);
    @(negedge clk);
    stateIn = x; keyIn = k;
    #1;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] x, k, y, z, a, b, c;
    repeat (3) @(negedge clk);
    chk("R7 reset result", result0, '0);
    chk("R7 reset outValid", {63'b0, outValid0}, 64'd0);
    rstN = 1'b1;

    // R1: raw mixing equations through the identity-table instance
    for (int v = 0; v < 16; v++) begin
      for (int s = 0; s < 3; s++) begin
        int n;
        logic [3:0] e;
        logic [3:0] xv;
        n = (s == 0) ? 0 : (s == 1) ? 7 : 15;
        xv = 4'(v);
        e[3] = xv[0] ^ xv[1] ^ xv[2];
        e[2] = xv[0] ^ xv[1] ^ xv[3];
        e[1] = xv[0] ^ xv[2] ^ xv[3];
        e[0] = xv[1] ^ xv[2] ^ xv[3];
        set1(64'(xv) << (4 * n), '0);
        chk("R1 mixing equation", result1, 64'(e) << (4 * n));
      end
    end

    // R8: same-cycle valid in combinational variant
    @(negedge clk); inValid = 1'b1; #1;
    chk("R8 outValid follows", {63'b0, outValid1}, 64'd1);
    inValid = 1'b0; #1;
    chk("R8 outValid drops", {63'b0, outValid1}, 64'd0);

    // R2: key bit position
    for (int s = 0; s < 3; s++) begin
      int bi;
      bi = (s == 0) ? 0 : (s == 1) ? 13 : 63;
      set1('0, 64'd1 << bi);
      chk("R2 key passes straight", result1, 64'd1 << bi);
      run0('0, 64'd1 << bi, y);
      chk("R2 key position", y, refLayer('0, 64'd1 << bi, 1'b0));
    end

    // R3: random vectors against the reference order
    for (int t = 0; t < 20; t++) begin
      x = {$urandom(), $urandom()};
      k = {$urandom(), $urandom()};
      run0(x, k, y);
      chk("R3 step order", y, refLayer(x, k, 1'b0));
      set1(x, k);
      chk("R3 comb variant", result1, refLayer(x, k, 1'b1));
    end

    // R9: default tables on single-bit probes
    run0(64'd1 << 1, '0, y);
    chk("R9 default tables bit1", y, refLayer(64'd1 << 1, '0, 1'b0));
    run0(64'd1 << 62, '0, y);
    chk("R9 default tables bit62", y, refLayer(64'd1 << 62, '0, 1'b0));

    // R10: single-bit weight
    for (int bi = 0; bi < 64; bi += 7) begin
      run0(64'd1 << bi, '0, y);
      chk("R10 weight three", 64'($countones(y)), 64'd3);
    end

    // R4: involution with zero key
    for (int t = 0; t < 8; t++) begin
      x = {$urandom(), $urandom()};
      run0(x, '0, y);
      run0(y, '0, z);
      chk("R4 involution", z, x);
    end

    // R5: linearity
    for (int t = 0; t < 6; t++) begin
      x = {$urandom(), $urandom()};
      k = {$urandom(), $urandom()};
      run0(x, '0, a);
      run0('0, k, b);
      run0(x, k, c);
      chk("R5 linearity", c, a ^ b);
    end

    // R6: hold while strobe low
    run0(64'h0123_4567_89AB_CDEF, 64'h1, y);
    @(negedge clk);
    stateIn = 64'hFFFF_0000_FFFF_0000; keyIn = 64'h55; inValid = 1'b0;
    @(negedge clk);
    chk("R6 hold", result0, y);
    chk("R6 valid low", {63'b0, outValid0}, 64'd0);

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule